// File: doc/BRIEF.md
# Audio Processor Control Register Slave (I2C, write-only)

This block is a receive-only I2C target that holds the control settings of an analog audio processor: source selection, input gain, per-side volume, output mode, surround level, sum-channel gain, bass, treble and four open-drain port pins. SCL and SDA are oversampled by a faster system clock. The block finds start and stop conditions, matches a fixed 7-bit device address, and then takes one subaddress byte and one data byte. It acknowledges each byte it accepts by pulling SDA low during the ninth clock.

Each accepted data byte is decoded by subaddress. Its fields update the matching registers, which drive the analog switch controls as plain parallel outputs. Out-of-range codes are acknowledged but discarded, so the analog side never sees an undefined setting. Reset puts every setting into a muted and safe state.

Top module: `snd_ctl_i2c_slave`

## Requirements
- R1: Only the address byte 0xEE (device address 1110111 with the R/W bit 0) is acknowledged. Any other address byte, including 0xEF (a read request), gets no acknowledge, and the rest of that transfer is ignored until the next start or stop.
- R2: Bytes are taken MSB first on sampled SCL rising edges. An accepted byte is acknowledged by asserting sda_oe_o from the SCL fall after its eighth bit until the SCL fall that ends the ninth clock. sda_oe_o only rises while SCL is low.
- R3: SDA falling while SCL is high is a start condition, and SDA rising while SCL is high is a stop condition. A repeated start in the middle of a byte abandons the partial transfer, writes nothing, and restarts address matching.
- R4: Subaddresses 0x01 to 0x06 are acknowledged. Any other subaddress is not acknowledged, and its data byte is neither acknowledged nor written.
- R5: Subaddress 0x01: bits 2:0 select the source (0 mute, 1..4 sources A..D) and bits 5:3 select the gain (000 0 dB, 010 -4 dB, 011 -6 dB, 110 +4 dB, 111 +6 dB). If the source code is above 4 or the gain code is not one of these five, the whole byte is discarded.
- R6: Subaddress 0x02: bits 5:0 are a volume step code from 0 to 48 (48 means muted). Bit 6 selects the left channel and bit 7 the right channel. A code above 48, or both select bits at 0, leaves both volumes unchanged.
- R7: Subaddress 0x03: bits 1:0 are the output mode (00 through, 01 matrix, 10 mono, 11 pseudo-stereo), bits 4:2 the surround setting (000 off), and bits 7:5 the sum-channel gain (000 mute, 001..111 rising steps).
- R8: While the output mode is mono, surround_o reads 000. The stored surround setting is kept and reappears once another mode is selected.
- R9: Subaddresses 0x04 (bass) and 0x05 (treble) take a sign-magnitude code: bit 4 is the sign (1 = cut), bits 3:0 the magnitude in 2 dB units. A magnitude above 10 for bass or above 9 for treble discards the byte. Bits 7:5 are ignored.
- R10: Subaddress 0x06: a 0 in data bit n (n = 0..3) turns port n into a current sink (port_sink_o[n] = 1), and a 1 leaves it open. A byte with any of bits 7:4 set is discarded.
- R11: After reset the source is mute, the gain is 0 dB, both volumes are 48, the mode is through, surround is off, the sum gain is mute, bass and treble are 0, and all ports are open.
- R12: Only one data byte is taken per transfer. Further bytes before the next start or stop are not acknowledged and write nothing.
- R13: Register outputs change only while SCL is high, in response to the sampled rising edge of a data byte's eighth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge) |
| src_sel_o | output | 3 | Source select code |
| gain_sel_o | output | 3 | Input gain code |
| vol_left_o | output | 6 | Left volume step code |
| vol_right_o | output | 6 | Right volume step code |
| out_mode_o | output | 2 | Output mode |
| surround_o | output | 3 | Effective surround setting |
| sum_gain_o | output | 3 | Sum-channel output gain |
| bass_o | output | 5 | Bass sign-magnitude code |
| treble_o | output | 5 | Treble sign-magnitude code |
| port_sink_o | output | 4 | 1 = port n sinks current |

## Verification
The bench builds the block with its default device address and a two-stage synchronizer. SCL is held high and low for 30 system clocks each, well above the latency from synchronizer to edge detector to register. Because of this margin, a reference model that updates in mid-SCL-high can be compared on every other clock, and register updates can be shown to land only inside SCL-high windows. The default address lets the bench cover the exact match, a one-bit miss and the read-bit rejection.

// File: rtl/snd_ctl_pkg.sv
package snd_ctl_pkg;

    localparam int VOL_W   = 6;
    localparam int TONE_W  = 5;
    localparam int PORT_N  = 4;
    localparam int SEL_W   = 3;

    localparam logic [VOL_W-1:0] VOL_MUTE = VOL_W'(48);
    localparam logic [3:0]       BASS_MAX = 4'd10;
    localparam logic [3:0]       TREB_MAX = 4'd9;
    localparam logic [SEL_W-1:0] SRC_MAX  = 3'd4;

    localparam logic [7:0] SUB_INPUT = 8'h01;
    localparam logic [7:0] SUB_VOL   = 8'h02;
    localparam logic [7:0] SUB_OUT   = 8'h03;
    localparam logic [7:0] SUB_BASS  = 8'h04;
    localparam logic [7:0] SUB_TREB  = 8'h05;
    localparam logic [7:0] SUB_PORT  = 8'h06;

    localparam logic [1:0] MODE_MONO = 2'b10;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ADDR,
        RX_ACK_ADDR,
        RX_SUB,
        RX_ACK_SUB,
        RX_DATA,
        RX_ACK_DATA,
        RX_SKIP
    } rx_state_e;

    typedef struct packed {
        logic [SEL_W-1:0]  src;
        logic [SEL_W-1:0]  gain;
        logic [VOL_W-1:0]  vol_l;
        logic [VOL_W-1:0]  vol_r;
        logic [1:0]        mode;
        logic [SEL_W-1:0]  surr;
        logic [SEL_W-1:0]  sum;
        logic [TONE_W-1:0] bass;
        logic [TONE_W-1:0] treb;
        logic [PORT_N-1:0] port_open;
    } ctl_regs_t;

    function automatic logic sub_known(input logic [7:0] s);
        return (s >= SUB_INPUT) && (s <= SUB_PORT);
    endfunction

    function automatic logic gain_legal(input logic [SEL_W-1:0] g);
        case (g)
            3'b000, 3'b010, 3'b011, 3'b110, 3'b111: return 1'b1;
            default:                                return 1'b0;
        endcase
    endfunction

    function automatic logic tone_legal(input logic [TONE_W-1:0] c,
                                        input logic [3:0] lim);
        return c[3:0] <= lim;
    endfunction

endpackage

// File: rtl/snd_bus_sampler.sv
module snd_bus_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sync;
        logic [SYNC_STAGES-1:0] sda_sync;
        logic                   scl_prev;
        logic                   sda_prev;
    } smp_t;

    smp_t smp_d, smp_q;
    logic scl_lvl;

    always_comb begin
        smp_d          = smp_q;
        smp_d.scl_sync = {smp_q.scl_sync[TOP-1:0], scl_i};
        smp_d.sda_sync = {smp_q.sda_sync[TOP-1:0], sda_i};
        smp_d.scl_prev = smp_q.scl_sync[TOP];
        smp_d.sda_prev = smp_q.sda_sync[TOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '1;
        else        smp_q <= smp_d;
    end

    assign scl_lvl   = smp_q.scl_sync[TOP];
    assign sda_lvl   = smp_q.sda_sync[TOP];
    assign scl_rise  =  scl_lvl & ~smp_q.scl_prev;
    assign scl_fall  = ~scl_lvl &  smp_q.scl_prev;
    assign start_evt =  scl_lvl & smp_q.scl_prev &  smp_q.sda_prev & ~sda_lvl;
    assign stop_evt  =  scl_lvl & smp_q.scl_prev & ~smp_q.sda_prev &  sda_lvl;

endmodule

// File: rtl/snd_i2c_rx.sv
module snd_i2c_rx
    import snd_ctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h77
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_evt,
    input  logic       stop_evt,
    output logic       sda_oe,
    output logic       wr_stb,
    output logic [7:0] wr_sub,
    output logic [7:0] wr_data
);

    localparam logic [7:0] ADDR_BYTE = {DEV_ADDR, 1'b0};

    typedef struct packed {
        rx_state_e  st;
        logic [2:0] bitcnt;
        logic [7:0] sh;
        logic [7:0] sub;
        logic       oe;
        logic       wr;
    } rx_t;

    rx_t rx_d, rx_q;
    logic [7:0] byte_w;
    logic       last_bit;

    assign byte_w   = {rx_q.sh[6:0], sda_lvl};
    assign last_bit = (rx_q.bitcnt == 3'd7);

    always_comb begin
        rx_d    = rx_q;
        rx_d.wr = 1'b0;
        if (stop_evt) begin
            rx_d.st     = RX_IDLE;
            rx_d.oe     = 1'b0;
            rx_d.bitcnt = '0;
        end else if (start_evt) begin
            rx_d.st     = RX_ADDR;
            rx_d.oe     = 1'b0;
            rx_d.bitcnt = '0;
        end else begin
            case (rx_q.st)
                RX_ADDR, RX_SUB, RX_DATA: begin
                    if (scl_rise) begin
                        rx_d.sh     = byte_w;
                        rx_d.bitcnt = rx_q.bitcnt + 3'd1;
                        if (last_bit) begin
                            if (rx_q.st == RX_ADDR) begin
                                rx_d.st = (byte_w == ADDR_BYTE) ? RX_ACK_ADDR : RX_SKIP;
                            end else if (rx_q.st == RX_SUB) begin
                                rx_d.sub = byte_w;
                                rx_d.st  = sub_known(byte_w) ? RX_ACK_SUB : RX_SKIP;
                            end else begin
                                rx_d.wr = 1'b1;
                                rx_d.st = RX_ACK_DATA;
                            end
                        end
                    end
                end
                RX_ACK_ADDR, RX_ACK_SUB, RX_ACK_DATA: begin
                    if (scl_fall) begin
                        if (!rx_q.oe) begin
                            rx_d.oe = 1'b1;
                        end else begin
                            rx_d.oe     = 1'b0;
                            rx_d.bitcnt = '0;
                            case (rx_q.st)
                                RX_ACK_ADDR: rx_d.st = RX_SUB;
                                RX_ACK_SUB:  rx_d.st = RX_DATA;
                                default:     rx_d.st = RX_SKIP;
                            endcase
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q.st     <= RX_IDLE;
            rx_q.bitcnt <= '0;
            rx_q.sh     <= '0;
            rx_q.sub    <= '0;
            rx_q.oe     <= 1'b0;
            rx_q.wr     <= 1'b0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign sda_oe  = rx_q.oe;
    assign wr_stb  = rx_q.wr;
    assign wr_sub  = rx_q.sub;
    assign wr_data = rx_q.sh;

endmodule

// File: rtl/snd_ctl_regs.sv
module snd_ctl_regs
    import snd_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [7:0]        wr_sub,
    input  logic [7:0]        wr_data,
    output logic [SEL_W-1:0]  src_sel,
    output logic [SEL_W-1:0]  gain_sel,
    output logic [VOL_W-1:0]  vol_left,
    output logic [VOL_W-1:0]  vol_right,
    output logic [1:0]        out_mode,
    output logic [SEL_W-1:0]  surround,
    output logic [SEL_W-1:0]  sum_gain,
    output logic [TONE_W-1:0] bass,
    output logic [TONE_W-1:0] treble,
    output logic [PORT_N-1:0] port_sink
);

    ctl_regs_t reg_d, reg_q;

    localparam ctl_regs_t RESET_VAL = '{
        src:       '0,
        gain:      '0,
        vol_l:     VOL_MUTE,
        vol_r:     VOL_MUTE,
        mode:      '0,
        surr:      '0,
        sum:       '0,
        bass:      '0,
        treb:      '0,
        port_open: '1
    };

    always_comb begin
        reg_d = reg_q;
        if (wr_stb) begin
            case (wr_sub)
                SUB_INPUT: begin
                    if (wr_data[2:0] <= SRC_MAX && gain_legal(wr_data[5:3])) begin
                        reg_d.src  = wr_data[2:0];
                        reg_d.gain = wr_data[5:3];
                    end
                end
                SUB_VOL: begin
                    if (wr_data[VOL_W-1:0] <= VOL_MUTE) begin
                        if (wr_data[6]) reg_d.vol_l = wr_data[VOL_W-1:0];
                        if (wr_data[7]) reg_d.vol_r = wr_data[VOL_W-1:0];
                    end
                end
                SUB_OUT: begin
                    reg_d.mode = wr_data[1:0];
                    reg_d.surr = wr_data[4:2];
                    reg_d.sum  = wr_data[7:5];
                end
                SUB_BASS: begin
                    if (tone_legal(wr_data[TONE_W-1:0], BASS_MAX))
                        reg_d.bass = wr_data[TONE_W-1:0];
                end
                SUB_TREB: begin
                    if (tone_legal(wr_data[TONE_W-1:0], TREB_MAX))
                        reg_d.treb = wr_data[TONE_W-1:0];
                end
                SUB_PORT: begin
                    if (wr_data[7:PORT_N] == '0)
                        reg_d.port_open = wr_data[PORT_N-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= RESET_VAL;
        else        reg_q <= reg_d;
    end

    assign src_sel   = reg_q.src;
    assign gain_sel  = reg_q.gain;
    assign vol_left  = reg_q.vol_l;
    assign vol_right = reg_q.vol_r;
    assign out_mode  = reg_q.mode;
    assign surround  = (reg_q.mode == MODE_MONO) ? '0 : reg_q.surr;
    assign sum_gain  = reg_q.sum;
    assign bass      = reg_q.bass;
    assign treble    = reg_q.treb;

    for (genvar p = 0; p < PORT_N; p++) begin : g_port
        assign port_sink[p] = ~reg_q.port_open[p];
    end

endmodule

// File: rtl/snd_ctl_i2c_slave.sv
module snd_ctl_i2c_slave
    import snd_ctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h77,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [SEL_W-1:0]  src_sel_o,
    output logic [SEL_W-1:0]  gain_sel_o,
    output logic [VOL_W-1:0]  vol_left_o,
    output logic [VOL_W-1:0]  vol_right_o,
    output logic [1:0]        out_mode_o,
    output logic [SEL_W-1:0]  surround_o,
    output logic [SEL_W-1:0]  sum_gain_o,
    output logic [TONE_W-1:0] bass_o,
    output logic [TONE_W-1:0] treble_o,
    output logic [PORT_N-1:0] port_sink_o
);

    logic       sda_lvl;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_evt;
    logic       stop_evt;
    logic       wr_stb;
    logic [7:0] wr_sub;
    logic [7:0] wr_data;

    snd_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    snd_i2c_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .sda_oe    (sda_oe_o),
        .wr_stb    (wr_stb),
        .wr_sub    (wr_sub),
        .wr_data   (wr_data)
    );

    snd_ctl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .wr_sub    (wr_sub),
        .wr_data   (wr_data),
        .src_sel   (src_sel_o),
        .gain_sel  (gain_sel_o),
        .vol_left  (vol_left_o),
        .vol_right (vol_right_o),
        .out_mode  (out_mode_o),
        .surround  (surround_o),
        .sum_gain  (sum_gain_o),
        .bass      (bass_o),
        .treble    (treble_o),
        .port_sink (port_sink_o)
    );

endmodule

// File: rtl/snd_ctl_checker.sv
module snd_ctl_checker
    import snd_ctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe_o,
    input logic [SEL_W-1:0]  src_sel_o,
    input logic [SEL_W-1:0]  gain_sel_o,
    input logic [VOL_W-1:0]  vol_left_o,
    input logic [VOL_W-1:0]  vol_right_o,
    input logic [1:0]        out_mode_o,
    input logic [SEL_W-1:0]  surround_o,
    input logic [TONE_W-1:0] bass_o,
    input logic [TONE_W-1:0] treble_o,
    input logic [PORT_N-1:0] port_sink_o
);

    assert_ack_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i);

    assert_src_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        src_sel_o <= SRC_MAX && gain_legal(gain_sel_o));

    assert_vol_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vol_left_o <= VOL_MUTE && vol_right_o <= VOL_MUTE);

    assert_mono_no_surround_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_mode_o == MODE_MONO |-> surround_o == '0);

    assert_tone_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bass_o[3:0] <= BASS_MAX && treble_o[3:0] <= TREB_MAX);

    assert_update_scl_high_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(vol_left_o) || !$stable(vol_right_o) || !$stable(bass_o)
         || !$stable(treble_o) || !$stable(port_sink_o) || !$stable(out_mode_o))
        |-> scl_i);

endmodule

bind snd_ctl_i2c_slave snd_ctl_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_oe_o    (sda_oe_o),
    .src_sel_o   (src_sel_o),
    .gain_sel_o  (gain_sel_o),
    .vol_left_o  (vol_left_o),
    .vol_right_o (vol_right_o),
    .out_mode_o  (out_mode_o),
    .surround_o  (surround_o),
    .bass_o      (bass_o),
    .treble_o    (treble_o),
    .port_sink_o (port_sink_o)
);

// File: tb/snd_ctl_i2c_slave_test.sv
module snd_ctl_i2c_slave_test;

    localparam int H = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_line;
    logic       sda_oe_o;
    logic [2:0] src_sel_o, gain_sel_o, surround_o, sum_gain_o;
    logic [5:0] vol_left_o, vol_right_o;
    logic [1:0] out_mode_o;
    logic [4:0] bass_o, treble_o;
    logic [3:0] port_sink_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit cmp_en  = 1'b0;
    bit win     = 1'b0;

    int m_src = 0, m_gain = 0, m_vl = 48, m_vr = 48, m_mode = 0;
    int m_surr = 0, m_sum = 0, m_bass = 0, m_treb = 0, m_sink = 0;

    always #2.5 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe_o;

    snd_ctl_i2c_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe_o), .src_sel_o(src_sel_o), .gain_sel_o(gain_sel_o),
        .vol_left_o(vol_left_o), .vol_right_o(vol_right_o),
        .out_mode_o(out_mode_o), .surround_o(surround_o),
        .sum_gain_o(sum_gain_o), .bass_o(bass_o), .treble_o(treble_o),
        .port_sink_o(port_sink_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            if (n_fail < 30)
                $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void model_apply(input int s, input int v);
        int sel, g, ch, code;
        case (s)
            1: begin
                sel = v % 8; g = (v / 8) % 8;
                if (sel <= 4 && (g == 0 || g == 2 || g == 3 || g == 6 || g == 7)) begin
                    m_src = sel; m_gain = g;
                end
            end
            2: begin
                ch = v / 64; code = v % 64;
                if (code <= 48) begin
                    if (ch == 1 || ch == 3) m_vl = code;
                    if (ch == 2 || ch == 3) m_vr = code;
                end
            end
            3: begin m_mode = v % 4; m_surr = (v / 4) % 8; m_sum = v / 32; end
            4: if (v % 16 <= 10) m_bass = v % 32;
            5: if (v % 16 <= 9)  m_treb = v % 32;
            6: if (v / 16 == 0)  m_sink = 15 - v;
            default: ;
        endcase
    endfunction

    // Per-clock comparison; outside the update window nothing may move (R13).
    always @(negedge clk) begin
        if (cmp_en && !win) begin
            check(int'(src_sel_o) == m_src && int'(gain_sel_o) == m_gain, "R5",
                  int'(src_sel_o) * 8 + int'(gain_sel_o), m_src * 8 + m_gain);
            check(int'(vol_left_o) == m_vl, "R6 left", int'(vol_left_o), m_vl);
            check(int'(vol_right_o) == m_vr, "R6 right", int'(vol_right_o), m_vr);
            check(int'(out_mode_o) == m_mode && int'(sum_gain_o) == m_sum, "R7",
                  int'(out_mode_o) * 8 + int'(sum_gain_o), m_mode * 8 + m_sum);
            check(int'(surround_o) == ((m_mode == 2) ? 0 : m_surr), "R8",
                  int'(surround_o), (m_mode == 2) ? 0 : m_surr);
            check(int'(bass_o) == m_bass && int'(treble_o) == m_treb, "R9",
                  int'(bass_o) * 32 + int'(treble_o), m_bass * 32 + m_treb);
            check(int'(port_sink_o) == m_sink, "R10", int'(port_sink_o), m_sink);
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic send_start();
        wclk(4); m_sda = 1'b1; wclk(H);
        m_scl = 1'b1; wclk(H);
        m_sda = 1'b0; wclk(H);
        m_scl = 1'b0;
    endtask

    task automatic send_stop();
        wclk(4); m_sda = 1'b0; wclk(H);
        m_scl = 1'b1; wclk(H);
        m_sda = 1'b1; wclk(H);
    endtask

    task automatic send_bit(input logic b);
        wclk(4); m_sda = b; wclk(H - 4);
        m_scl = 1'b1; wclk(H);
        m_scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit upd, input int s, output bit ak);
        for (int i = 7; i >= 1; i--) send_bit(b[i]);
        wclk(4); m_sda = b[0]; wclk(H - 4);
        if (upd) win = 1'b1;
        m_scl = 1'b1; wclk(H / 2);
        if (upd) begin model_apply(s, int'(b)); win = 1'b0; end
        wclk(H - H / 2);
        m_scl = 1'b0;
        wclk(4); m_sda = 1'b1; wclk(H - 4);
        m_scl = 1'b1; wclk(H / 2);
        ak = sda_oe_o;
        wclk(H - H / 2);
        m_scl = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] s, input logic [7:0] v,
                            input bit extra);
        bit ak;
        bit a_ok = (a == 8'hEE);
        bit s_ok = a_ok && (s >= 8'h01) && (s <= 8'h06);
        send_start();
        send_byte(a, 1'b0, 0, ak);
        check(ak == a_ok, "R1 address ack", int'(ak), int'(a_ok));
        send_byte(s, 1'b0, 0, ak);
        check(ak == s_ok, "R4 subaddress ack", int'(ak), int'(s_ok));
        send_byte(v, s_ok, int'(s), ak);
        check(ak == s_ok, "R2 data ack", int'(ak), int'(s_ok));
        if (extra) begin
            send_byte(8'h00, 1'b0, 0, ak);
            check(ak == 1'b0, "R12 extra byte", int'(ak), 0);
        end
        send_stop();
    endtask

    initial begin : watchdog
        wclk(190000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        bit ak;
        wclk(10);
        rst_n = 1'b1;
        wclk(3);
        // R11: reset state
        check(vol_left_o == 6'd48 && vol_right_o == 6'd48, "R11 volume", int'(vol_left_o), 48);
        check(src_sel_o == 3'd0 && sum_gain_o == 3'd0, "R11 mute", int'(src_sel_o), 0);
        check(port_sink_o == 4'd0 && bass_o == 5'd0 && treble_o == 5'd0, "R11 ports/tone",
              int'(port_sink_o), 0);
        check(sda_oe_o == 1'b0, "R11 sda released", int'(sda_oe_o), 0);
        cmp_en = 1'b1;

        do_write(8'hEE, 8'h01, 8'h32, 1'b0);       // R5 source B, +4 dB
        do_write(8'hEE, 8'h01, 8'h0C, 1'b0);       // R5 gain 001 illegal
        do_write(8'hEE, 8'h01, 8'h05, 1'b0);       // R5 source 5 illegal
        do_write(8'hEE, 8'h02, 8'h54, 1'b0);       // R6 left 20
        do_write(8'hEE, 8'h02, 8'hB0, 1'b0);       // R6 right 48
        do_write(8'hEE, 8'h02, 8'hC7, 1'b0);       // R6 both 7
        do_write(8'hEE, 8'h02, 8'h05, 1'b0);       // R6 channel bits 00
        do_write(8'hEE, 8'h02, 8'hF1, 1'b0);       // R6 code 49
        do_write(8'hEE, 8'h02, 8'h40, 1'b0);       // R6 left 0 dB
        do_write(8'hEE, 8'h03, 8'h76, 1'b0);       // R7/R8 mono with surround 5
        check(surround_o == 3'd0, "R8 mono gate", int'(surround_o), 0);
        do_write(8'hEE, 8'h03, 8'h75, 1'b0);       // R8 matrix restores surround
        check(surround_o == 3'd5, "R8 restore", int'(surround_o), 5);
        do_write(8'hEE, 8'h04, 8'h0A, 1'b0);       // R9 bass +20
        do_write(8'hEE, 8'h04, 8'h0B, 1'b0);       // R9 bass 11 rejected
        do_write(8'hEE, 8'h04, 8'hFA, 1'b0);       // R9 bass -20, bits 7:5 ignored
        do_write(8'hEE, 8'h05, 8'h19, 1'b0);       // R9 treble -18
        do_write(8'hEE, 8'h05, 8'h0A, 1'b0);       // R9 treble 10 rejected
        do_write(8'hEE, 8'h06, 8'h05, 1'b0);       // R10 ports 1,3 sink
        do_write(8'hEE, 8'h06, 8'h15, 1'b0);       // R10 upper bit set
        do_write(8'hEC, 8'h02, 8'hC0, 1'b0);       // R1 wrong address
        do_write(8'hEF, 8'h02, 8'hC0, 1'b0);       // R1 read request
        do_write(8'hEE, 8'h07, 8'hC0, 1'b0);       // R4 subaddress 7
        do_write(8'hEE, 8'h00, 8'hC0, 1'b0);       // R4 subaddress 0
        do_write(8'hEE, 8'h06, 8'h0F, 1'b1);       // R12 extra byte after data

        // R3: repeated start inside a data byte abandons it
        send_start();
        send_byte(8'hEE, 1'b0, 0, ak);
        check(ak, "R3 address ack", int'(ak), 1);
        send_byte(8'h02, 1'b0, 0, ak);
        check(ak, "R3 subaddress ack", int'(ak), 1);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        send_start();
        send_byte(8'hEE, 1'b0, 0, ak);
        check(ak, "R3 ack after repeated start", int'(ak), 1);
        send_byte(8'h02, 1'b0, 0, ak);
        send_byte(8'hDE, 1'b1, 2, ak);             // both volumes 30
        check(ak, "R3 data ack", int'(ak), 1);
        send_stop();
        check(vol_left_o == 6'd30 && vol_right_o == 6'd30, "R3 volume", int'(vol_left_o), 30);

        wclk(20);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule